// File: doc/BRIEF.md
# Serial Register Access Slave

This block gives an external host read and write access to a bank of byte-wide configuration registers over a four-wire serial link. The link has an active-low select, a serial clock, a data input and a data output with its own drive enable. Every transfer opens with a device byte: a fixed 7-bit device identity and a direction bit. A write then supplies a register index byte and any number of data bytes. A read streams register contents out, starting at the index that the previous transfer left behind. After each data byte in either direction, the register index advances to the next register and wraps at the end of the bank.

All serial inputs are brought into the system clock domain by synchronizer flops, and both edges of the serial clock are detected there. The serial clock must therefore hold each level for at least three system clock cycles. The bank also has a parallel port on the system clock side. Chip logic uses it to read any register combinationally and to write one register per cycle.

The transfer controller is a state machine with six states. IDLE holds while select is high. CHIP collects the device byte. PTR collects the register index. WDATA stores incoming data bytes. RDATA streams bytes out. IGNORE absorbs the rest of a transfer that was meant for another device. The transitions are:

- Select going high sends any state to IDLE.
- Select low moves IDLE to CHIP.
- A completed device byte moves CHIP to PTR when it matches with the direction bit low, to RDATA when it matches with the direction bit high, and to IGNORE when it does not match.
- A completed index byte moves PTR to WDATA.
- WDATA, RDATA and IGNORE hold until select rises.

Top module: `spi_reg_port`

## Requirements
- R1: After select falls, the first eight bits sampled on rising serial clock edges form the device byte, MSB first. The upper seven bits must equal 1001111 and the last bit selects the direction (1 = read, 0 = write). The write device byte is 0x9E and the read device byte is 0x9F.
- R2: In a write, the byte after the device byte becomes the register index. Only its low five bits are used, so index byte 0xE3 selects register 3.
- R3: Each further write byte is stored in the register at the current index, and the index then advances by one, wrapping from 31 to 0.
- R4: In a read, from the falling serial clock edge after the device byte onward, `sdo` presents the register at the current index MSB first and changes only on falling edges. The index advances after every eight rising edges and wraps from 31 to 0.
- R5: `sdo_oe` is high only while read data is being shifted out, and `sdo` is 0 whenever `sdo_oe` is low.
- R6: A device byte whose upper seven bits differ from 1001111 makes the rest of the transfer have no effect: no register changes, the index is kept and `sdo_oe` stays low.
- R7: Select going high discards a partial byte and restarts bit counting for the next transfer, while the register index is preserved across transfers.
- R8: `host_rdata` shows register `host_addr` combinationally. A write through `host_we` is visible from the next clock cycle and to later serial reads.
- R9: Reset clears every register and the index to 0, and leaves `sdo_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial data out of the block |
| sdo_oe | output | 1 | Drive enable for the serial output pad |
| host_we | input | 1 | Parallel-side write strobe |
| host_addr | input | 5 | Parallel-side register select |
| host_wdata | input | 8 | Parallel-side write data |
| host_rdata | output | 8 | Parallel-side read data |

## Verification
The bench drives index bytes with set upper bits; a design that did not mask them would write or read the wrong register. It writes and reads across the 31-to-0 boundary, where a counter that was not wrapped would fall off the bank. It sends device bytes for another device in both directions: a decoder that was too loose would corrupt registers or drive the output line. It also opens a transfer that select aborts after five bits, then a transfer that sets only the index. A design that kept its bit counter would misalign every later byte, and one that cleared the index on select would stream from register 0.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHIP,
        ST_PTR,
        ST_WDATA,
        ST_RDATA,
        ST_IGNORE
    } port_state_e;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= RST_VAL;
                end else begin
                    if (g == 0) stage_q[g] <= d_in;
                    else        stage_q[g] <= stage_q[(g > 0) ? g - 1 : 0];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);

    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_we,
    input  logic [AW-1:0]     ser_addr,
    input  logic [DATA_W-1:0] ser_wdata,
    output logic [DATA_W-1:0] ser_rdata,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_q[g] <= '0;
                end else if (ser_we && ser_addr == AW'(g)) begin
                    mem_q[g] <= ser_wdata;
                end else if (host_we && host_addr == AW'(g)) begin
                    mem_q[g] <= host_wdata;
                end
            end
        end
    endgenerate

    assign ser_rdata  = mem_q[ser_addr];
    assign host_rdata = mem_q[host_addr];

endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
    import spi_regs_pkg::*;
#(
    parameter int                REG_COUNT   = 32,
    parameter int                DATA_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-2:0] DEV_ADDR    = 7'b1001111,
    localparam int               AW          = $clog2(REG_COUNT),
    localparam int               BIT_W       = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
    localparam logic [AW-1:0]    LAST_REG = AW'(REG_COUNT - 1);

    // synchronized pins: {cs_n, sclk, sdi}
    logic [2:0] pins_s;
    logic       cs_act, sclk_s, sdi_s;
    logic       rise, fall;

    spi_in_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({cs_n, sclk, sdi}),
        .d_out (pins_s)
    );

    assign cs_act = ~pins_s[2];
    assign sclk_s = pins_s[1];
    assign sdi_s  = pins_s[0];

    spi_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sclk_s),
        .rise  (rise),
        .fall  (fall)
    );

    port_state_e       state, nxt_state;
    logic [BIT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg, out_sh, byte_in, rd_data;
    logic [AW-1:0]     ptr, ptr_inc;
    logic              drive, byte_done, addr_hit, wr_en;

    assign byte_in   = {shreg[DATA_W-2:0], sdi_s};
    assign byte_done = cs_act && rise && (cnt == LAST_BIT);
    assign addr_hit  = (byte_in[DATA_W-1:1] == DEV_ADDR);
    assign ptr_inc   = (ptr == LAST_REG) ? '0 : ptr + AW'(1);
    assign wr_en     = byte_done && (state == ST_WDATA);

    spi_reg_bank #(
        .DEPTH  (REG_COUNT),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_we     (wr_en),
        .ser_addr   (ptr),
        .ser_wdata  (byte_in),
        .ser_rdata  (rd_data),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    // next-state decode
    always_comb begin
        nxt_state = state;
        if (!cs_act) begin
            nxt_state = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_CHIP: begin
                    if (!byte_done)       nxt_state = ST_CHIP;
                    else if (!addr_hit)   nxt_state = ST_IGNORE;
                    else if (byte_in[0])  nxt_state = ST_RDATA;
                    else                  nxt_state = ST_PTR;
                end
                ST_PTR:    if (byte_done) nxt_state = ST_WDATA;
                ST_WDATA:  nxt_state = ST_WDATA;
                ST_RDATA:  nxt_state = ST_RDATA;
                ST_IGNORE: nxt_state = ST_IGNORE;
                default:   nxt_state = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // shift path, bit counter and register index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            shreg  <= '0;
            out_sh <= '0;
            ptr    <= '0;
            drive  <= 1'b0;
        end else if (!cs_act) begin
            cnt   <= '0;
            drive <= 1'b0;
        end else begin
            if (rise) begin
                shreg <= byte_in;
                cnt   <= cnt + BIT_W'(1);
            end
            if (byte_done) begin
                unique case (state)
                    ST_PTR:             ptr <= byte_in[AW-1:0];
                    ST_WDATA, ST_RDATA: ptr <= ptr_inc;
                    default:            ptr <= ptr;
                endcase
            end
            if (fall && state == ST_RDATA) begin
                drive <= 1'b1;
                if (cnt == '0) out_sh <= rd_data;
                else           out_sh <= {out_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        sdo_oe = drive && (state == ST_RDATA);
        sdo    = sdo_oe ? out_sh[DATA_W-1] : 1'b0;
    end

endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk
    import spi_regs_pkg::*;
#(
    parameter int AW    = 5,
    parameter int BIT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_act,
    input logic             fall,
    input logic             byte_done,
    input port_state_e      state,
    input logic [BIT_W-1:0] cnt,
    input logic [AW-1:0]    ptr,
    input logic             sdo,
    input logic             sdo_oe
);

    localparam logic [AW-1:0] TOP_IDX = '1;

    AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RDATA) |-> !sdo_oe);  // R5

    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);  // R5

    AST_SDO_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe)) |-> ($stable(sdo) || $past(fall)));  // R4

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WDATA || state == ST_RDATA) && byte_done && ptr == TOP_IDX)
        |=> (ptr == '0));  // R3

    AST_IGNORE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE && cs_act) |=> (state == ST_IGNORE && !sdo_oe));  // R6

    AST_IGNORE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |=> $stable(ptr));  // R6

    AST_DESELECT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (cnt == '0 && $stable(ptr)));  // R7

endmodule

bind spi_reg_port spi_reg_port_chk #(
    .AW    (AW),
    .BIT_W (BIT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .fall      (fall),
    .byte_done (byte_done),
    .state     (state),
    .cnt       (cnt),
    .ptr       (ptr),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
);

// File: tb/spi_reg_port_test.sv
module spi_reg_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic       sdo, sdo_oe;
    logic       host_we = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;

    int checks = 0;
    int errors = 0;
    int stray  = 0;
    bit rd_win = 1'b0;
    bit done   = 1'b0;

    logic [7:0] model [32];
    logic [4:0] ptr_m = '0;
    logic [7:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_reg_port uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sdi        (sdi),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: collects bytes from sdo on rising sclk and compares with the scoreboard
    int         mon_cnt = 0;
    logic [7:0] mon_byte = '0;
    always @(posedge sclk) begin
        if (sdo_oe) begin
            mon_byte = {mon_byte[6:0], sdo};
            mon_cnt++;
            if (mon_cnt == 8) begin
                mon_cnt = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected byte", 32'(mon_byte), 32'hx);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(mon_byte == e, "R4 read byte", 32'(mon_byte), 32'(e));
                end
            end
        end
    end

    // stray drive watcher for R5 and R6
    always @(negedge clk) begin
        if (rst_n && ((sdo_oe && !rd_win) || (!sdo_oe && sdo))) stray++;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sdi = b[i];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic begin_xfer();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic end_xfer();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic ser_write(input logic [7:0] idx, input int n, input logic [7:0] base);
        begin_xfer();
        shift_byte(8'h9E);
        shift_byte(idx);
        ptr_m = idx[4:0];
        for (int k = 0; k < n; k++) begin
            shift_byte(base + 8'(k * 17));
            model[ptr_m] = base + 8'(k * 17);
            ptr_m = ptr_m + 5'd1;
        end
        end_xfer();
    endtask

    task automatic ser_read(input int n, input string req);
        logic [4:0] p;
        p = ptr_m;
        mon_cnt = 0;
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(model[p]);
            p = p + 5'd1;
        end
        begin_xfer();
        shift_byte(8'h9F);
        rd_win = 1'b1;
        for (int k = 0; k < n; k++) begin
            shift_byte(8'h00);
            if (k == 0) chk(sdo_oe == 1'b1, {req, " R5 oe during read"}, 32'(sdo_oe), 32'd1);
        end
        end_xfer();
        rd_win = 1'b0;
        ptr_m = p;
        chk(exp_q.size() == 0, {req, " R4 all bytes seen"}, 32'(exp_q.size()), 32'd0);
    endtask

    task automatic host_check(input logic [4:0] a, input string req);
        host_addr = a;
        wait_clk(1);
        chk(host_rdata == model[a], req, 32'(host_rdata), 32'(model[a]));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);

        // R9: reset state
        chk(sdo_oe == 1'b0, "R9 oe after reset", 32'(sdo_oe), 32'd0);
        host_check(5'd0, "R9 register zero after reset");
        host_check(5'd31, "R9 last register zero after reset");

        // R8: parallel write then readback
        host_addr = 5'd5; host_wdata = 8'hA5; host_we = 1'b1;
        wait_clk(1);
        host_we = 1'b0;
        model[5] = 8'hA5;
        host_check(5'd5, "R8 host write visible");

        // R1 R2 R3: serial write at index 2, three bytes
        ser_write(8'h02, 3, 8'h11);
        host_check(5'd2, "R3 serial write reg2");
        host_check(5'd3, "R3 serial write reg3");
        host_check(5'd4, "R3 serial write reg4");

        // R4 R8: read continues from index 5 and sees host write
        ser_read(4, "R8 host value in serial read");

        // R2 R7: index-only write with upper bits set, then read in new transfer
        ser_write(8'hE3, 0, 8'h00);
        ser_read(3, "R2 masked index");

        // R3: write wrapping past the end
        ser_write(8'h1E, 4, 8'h40);
        host_check(5'd30, "R3 wrap reg30");
        host_check(5'd31, "R3 wrap reg31");
        host_check(5'd0,  "R3 wrap reg0");
        host_check(5'd1,  "R3 wrap reg1");

        // R4: read wrapping past the end
        ser_write(8'h1F, 0, 8'h00);
        ser_read(3, "R4 wrap read");

        // R6: foreign device write must not change anything
        begin_xfer();
        shift_byte(8'h9C);
        shift_byte(8'h10);
        shift_byte(8'hFF);
        end_xfer();
        host_check(5'd16, "R6 foreign write ignored");
        // R6: foreign device read must not drive
        begin_xfer();
        shift_byte(8'h9D);
        shift_byte(8'h00);
        end_xfer();
        ser_read(1, "R6 index kept after foreign access");

        // R7: aborted partial byte, then a clean read
        begin_xfer();
        for (int i = 0; i < 5; i++) begin
            sdi = 1'b1;
            wait_clk(HALF); sclk = 1'b1;
            wait_clk(HALF); sclk = 1'b0;
        end
        end_xfer();
        ser_read(2, "R7 realigned after abort");

        chk(stray == 0, "R5 R6 no stray output drive", 32'(stray), 32'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule